// File: doc/BRIEF.md
# Flash Access Address Mapper

This block lets a CPU reach one word-organized, paged flash array through two address views. In the code view, a byte pointer addresses the array from offset zero. A read strobe fetches the word the pointer names and returns the byte that pointer bit 0 selects. A programming strobe captures the word address, without bit 0, into a holding register that is split into a page number and a word-in-page index. Software may then move the pointer freely while the programming operation runs.

In the data view, the array shows through a 32 KB window that starts at data address 0x8000. A block-select input chooses which 32 KB slice of a larger array the window exposes. Byte loads return one byte a cycle after the strobe. Byte stores drive a single-lane write toward the array. The array itself is external and synchronous: it returns the addressed word one cycle after a read request. Flash timing, erase and page buffer contents are handled elsewhere.

Top module: `flash_addr_mapper`

## Requirements
- R1: A code-space read (`cs_rd` with no data-space hit in the same cycle) drives `arr_re` high and `arr_addr` equal to `cs_ptr` shifted right by one, in the same cycle.
- R2: One cycle after an accepted code-space read, `rd_valid` is 1 and `rd_src` is 0. `rd_data` is bits 7:0 of the returned word when pointer bit 0 was 0, and bits 15:8 when it was 1.
- R3: A data-space access (`d_re` or `d_we`) is claimed only when `d_addr[15]` is 1. Below 0x8000, `d_hit` stays 0, no array read or write is issued for it, and no read data follows.
- R4: For a claimed data-space access, `arr_addr` equals `{blk_sel, d_addr[14:1]}`. With the default 64 KB array, `blk_sel` is 1 bit and selects the lower or upper 32 KB.
- R5: One cycle after a claimed data-space read, `rd_valid` is 1 and `rd_src` is 1. The byte lane is chosen by `d_addr[0]` in the same way as in R2.
- R6: A claimed data-space store drives `arr_we` high and `arr_wdata` as `{d_wdata, d_wdata}`. `arr_be` is 2'b01 for an even address and 2'b10 for an odd one.
- R7: `prog_start` while idle sets `prog_busy`. It captures `cs_ptr[15:1]` into `prog_addr`, so pointer bit 0 has no effect. `prog_word` is the low 6 bits of `prog_addr` and `prog_page` is the remaining upper bits.
- R8: While `prog_busy` is 1, changes of `cs_ptr` leave `prog_addr`, `prog_page` and `prog_word` unchanged.
- R9: `prog_start` while busy is rejected: `prog_addr` keeps its value and `prog_err` becomes 1. `prog_err` stays 1 until the next accepted start clears it.
- R10: `prog_done` while busy clears `prog_busy` on the next cycle.
- R11: When a code-space read and a claimed data-space access fall in the same cycle, the data-space access drives the array and the code-space read is dropped (no `rd_valid` with `rd_src` 0 follows).
- R12: After reset, `rd_valid`, `prog_busy` and `prog_err` are 0 and `prog_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_ptr | input | 16 | Code-space byte pointer |
| cs_rd | input | 1 | Code-space byte read strobe |
| prog_start | input | 1 | Start a programming operation at `cs_ptr` |
| prog_done | input | 1 | Programming operation finished |
| d_addr | input | 16 | Data-space byte address |
| d_re | input | 1 | Data-space load strobe |
| d_we | input | 1 | Data-space store strobe |
| d_wdata | input | 8 | Data-space store byte |
| blk_sel | input | 1 | 32 KB block shown in the data window |
| d_hit | output | 1 | Data-space access claimed by this block |
| arr_addr | output | 15 | Word address to the array |
| arr_re | output | 1 | Array read request |
| arr_we | output | 1 | Array byte write request |
| arr_be | output | 2 | Array byte-lane enables |
| arr_wdata | output | 16 | Array write data |
| arr_rdata | input | 16 | Array read word, one cycle after `arr_re` |
| rd_valid | output | 1 | `rd_data` holds a returned byte |
| rd_src | output | 1 | 0 for code-space read, 1 for data-space read |
| rd_data | output | 8 | Returned byte |
| prog_busy | output | 1 | Programming operation in progress |
| prog_err | output | 1 | A start was rejected while busy |
| prog_addr | output | 15 | Latched programming word address |
| prog_page | output | 9 | Page field of `prog_addr` |
| prog_word | output | 6 | Word-in-page field of `prog_addr` |

## Verification
The hardest case to reach is a start that arrives while a programming operation is still busy, with the pointer already moved to a new value. If the latch were overwritten, the change would not show in any read path. The stimulus issues a start at an odd pointer and then moves the pointer. It strobes a second start before releasing the operation, and compares the address, page and word fields at each step. It also issues a code read in the same cycle as a window access, so that the dropped read can be seen from the source tag on the next cycle.

// File: rtl/flash_addr_mapper.sv
module flash_addr_mapper #(
  parameter int FLASH_KB = 64,
  parameter int PAGE_WW  = 6,
  localparam int AW  = $clog2(FLASH_KB * 512),
  localparam int BW  = AW - 14,
  localparam int BSW = (BW > 0) ? BW : 1,
  localparam int PW  = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PW-1:0]    cs_ptr,
  input  logic             cs_rd,
  input  logic             prog_start,
  input  logic             prog_done,
  input  logic [15:0]      d_addr,
  input  logic             d_re,
  input  logic             d_we,
  input  logic [7:0]       d_wdata,
  input  logic [BSW-1:0]   blk_sel,
  output logic             d_hit,
  output logic [AW-1:0]    arr_addr,
  output logic             arr_re,
  output logic             arr_we,
  output logic [1:0]       arr_be,
  output logic [15:0]      arr_wdata,
  input  logic [15:0]      arr_rdata,
  output logic             rd_valid,
  output logic             rd_src,
  output logic [7:0]       rd_data,
  output logic             prog_busy,
  output logic             prog_err,
  output logic [AW-1:0]    prog_addr,
  output logic [AW-PAGE_WW-1:0] prog_page,
  output logic [PAGE_WW-1:0]    prog_word
);

  logic [AW-1:0] win_addr;
  logic          cs_take;
  logic          rd_lane;
  logic          accept;

  generate
    if (BW > 0) begin : g_blk
      assign win_addr = {blk_sel, d_addr[14:1]};
    end else begin : g_flat
      logic unused_blk;
      assign unused_blk = ^blk_sel;
      assign win_addr = d_addr[14:1];
    end
  endgenerate

  assign d_hit     = d_addr[15] & (d_re | d_we);
  assign cs_take   = cs_rd & ~d_hit;
  assign arr_addr  = d_hit ? win_addr : cs_ptr[PW-1:1];
  assign arr_re    = (d_hit & d_re & ~d_we) | cs_take;
  assign arr_we    = d_hit & d_we;
  assign arr_be    = d_addr[0] ? 2'b10 : 2'b01;
  assign arr_wdata = {d_wdata, d_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_src   <= 1'b0;
      rd_lane  <= 1'b0;
    end else begin
      rd_valid <= arr_re;
      rd_src   <= d_hit;
      rd_lane  <= d_hit ? d_addr[0] : cs_ptr[0];
    end
  end

  assign rd_data = rd_lane ? arr_rdata[15:8] : arr_rdata[7:0];

  assign accept = prog_start & ~prog_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_busy <= 1'b0;
      prog_err  <= 1'b0;
      prog_addr <= '0;
    end else if (accept) begin
      prog_busy <= 1'b1;
      prog_err  <= 1'b0;
      prog_addr <= cs_ptr[PW-1:1];
    end else begin
      if (prog_start) prog_err <= 1'b1;
      if (prog_done)  prog_busy <= 1'b0;
    end
  end

  assign prog_word = prog_addr[PAGE_WW-1:0];
  assign prog_page = prog_addr[AW-1:PAGE_WW];

  a_r3_no_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    !d_addr[15] |-> !arr_we);
  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(arr_re));
  a_r6_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> $countones(arr_be) == 1);
  a_r8_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && $past(prog_busy)) |-> $stable(prog_addr));
  a_r9_reject_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start && prog_busy) |=> (prog_err && $stable(prog_addr)));
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && prog_busy && !prog_start) |=> !prog_busy);
  a_r11_data_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (d_hit && cs_rd) |=> !(rd_valid && !rd_src));

endmodule

// File: tb/tb_flash_addr_mapper.sv
module tb_flash_addr_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cs_ptr = '0;
  logic cs_rd = 1'b0, prog_start = 1'b0, prog_done = 1'b0;
  logic [15:0] d_addr = '0;
  logic d_re = 1'b0, d_we = 1'b0;
  logic [7:0] d_wdata = '0;
  logic [0:0] blk_sel = '0;
  logic d_hit, arr_re, arr_we, rd_valid, rd_src, prog_busy, prog_err;
  logic [14:0] arr_addr, prog_addr;
  logic [1:0] arr_be;
  logic [15:0] arr_wdata, arr_rdata;
  logic [7:0] rd_data;
  logic [8:0] prog_page;
  logic [5:0] prog_word;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flash_addr_mapper dut (
    .clk(clk), .rst_n(rst_n), .cs_ptr(cs_ptr), .cs_rd(cs_rd),
    .prog_start(prog_start), .prog_done(prog_done), .d_addr(d_addr),
    .d_re(d_re), .d_we(d_we), .d_wdata(d_wdata), .blk_sel(blk_sel),
    .d_hit(d_hit), .arr_addr(arr_addr), .arr_re(arr_re), .arr_we(arr_we),
    .arr_be(arr_be), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
    .rd_valid(rd_valid), .rd_src(rd_src), .rd_data(rd_data),
    .prog_busy(prog_busy), .prog_err(prog_err), .prog_addr(prog_addr),
    .prog_page(prog_page), .prog_word(prog_word));

  function automatic logic [15:0] model(input logic [14:0] a);
    return {a[7:0] ^ 8'h3C, a[14:7]};
  endfunction

  always_ff @(posedge clk) arr_rdata <= arr_re ? model(arr_addr) : 16'h0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {kind(0 code rd,1 data rd,2 data wr), blk, addr, word address, hit}
  localparam logic [34:0] VEC [12] = '{
    {2'd0, 1'b0, 16'h0000, 15'h0000, 1'b1},
    {2'd0, 1'b0, 16'h0001, 15'h0000, 1'b1},
    {2'd0, 1'b1, 16'hFFFF, 15'h7FFF, 1'b1},
    {2'd0, 1'b0, 16'h1234, 15'h091A, 1'b1},
    {2'd1, 1'b0, 16'h8000, 15'h0000, 1'b1},
    {2'd1, 1'b1, 16'h8001, 15'h4000, 1'b1},
    {2'd1, 1'b1, 16'hFFFE, 15'h7FFF, 1'b1},
    {2'd1, 1'b0, 16'hC003, 15'h2001, 1'b1},
    {2'd2, 1'b1, 16'h8005, 15'h4002, 1'b1},
    {2'd2, 1'b0, 16'h9000, 15'h0800, 1'b1},
    {2'd1, 1'b1, 16'h7FFF, 15'h0000, 1'b0},
    {2'd2, 1'b0, 16'h1000, 15'h0000, 1'b0}
  };

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!rd_valid && !prog_busy && !prog_err && prog_addr == 0, "R12 reset state",
        {rd_valid, prog_busy, prog_err, prog_addr}, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      logic [1:0] k;
      logic [15:0] a;
      logic [14:0] w;
      logic h, lane;
      logic [15:0] m;
      k = VEC[i][34:33]; blk_sel = VEC[i][32]; a = VEC[i][31:16];
      w = VEC[i][15:1]; h = VEC[i][0]; lane = a[0];
      m = model(w);
      @(negedge clk);
      if (k == 2'd0) begin cs_ptr = a; cs_rd = 1'b1; end
      else begin
        d_addr = a; d_re = (k == 2'd1); d_we = (k == 2'd2); d_wdata = a[7:0] ^ 8'h5A;
      end
      #1;
      if (k == 2'd0) begin
        chk(arr_re && arr_addr == w, "R1 code word address", {arr_re, arr_addr}, {1'b1, w});
      end else if (h) begin
        chk(d_hit && arr_addr == w, "R4 window address", {d_hit, arr_addr}, {1'b1, w});
        if (k == 2'd2)
          chk(arr_we && !arr_re && arr_be == (lane ? 2'b10 : 2'b01) &&
              arr_wdata == {2{a[7:0] ^ 8'h5A}}, "R6 store lanes",
              {arr_we, arr_be, arr_wdata}, {1'b1, lane ? 2'b10 : 2'b01, {2{a[7:0] ^ 8'h5A}}});
      end else begin
        chk(!d_hit && !arr_re && !arr_we, "R3 below window", {d_hit, arr_re, arr_we}, 0);
      end
      @(negedge clk);
      cs_rd = 1'b0; d_re = 1'b0; d_we = 1'b0;
      #1;
      if (k == 2'd0)
        chk(rd_valid && !rd_src && rd_data == (lane ? m[15:8] : m[7:0]), "R2 code byte",
            {rd_valid, rd_src, rd_data}, {2'b10, lane ? m[15:8] : m[7:0]});
      else if (k == 2'd1 && h)
        chk(rd_valid && rd_src && rd_data == (lane ? m[15:8] : m[7:0]), "R5 data byte",
            {rd_valid, rd_src, rd_data}, {2'b11, lane ? m[15:8] : m[7:0]});
      else
        chk(!rd_valid, "R3 no read data", rd_valid, 0);
    end

    // programming latch, odd pointer
    @(negedge clk); cs_ptr = 16'hA5C7; prog_start = 1'b1;
    @(negedge clk); prog_start = 1'b0; #1;
    chk(prog_busy && prog_addr == 15'h52E3 && prog_word == 6'h23 && prog_page == 9'h14B,
        "R7 latch and split", {prog_busy, prog_addr, prog_page, prog_word},
        {1'b1, 15'h52E3, 9'h14B, 6'h23});
    cs_ptr = 16'h1110;
    @(negedge clk); #1;
    chk(prog_addr == 15'h52E3 && prog_word == 6'h23, "R8 pointer move ignored",
        prog_addr, 15'h52E3);
    prog_start = 1'b1;
    @(negedge clk); prog_start = 1'b0; #1;
    chk(prog_err && prog_busy && prog_addr == 15'h52E3, "R9 busy start rejected",
        {prog_err, prog_busy, prog_addr}, {2'b11, 15'h52E3});
    prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0; #1;
    chk(!prog_busy && prog_err, "R10 done clears busy", {prog_busy, prog_err}, 2'b01);
    cs_ptr = 16'h0042; prog_start = 1'b1;
    @(negedge clk); prog_start = 1'b0; #1;
    chk(prog_busy && !prog_err && prog_addr == 15'h0021, "R9 accepted start clears error",
        {prog_busy, prog_err, prog_addr}, {2'b10, 15'h0021});
    prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;

    // code read colliding with a window store, then with a window load
    cs_ptr = 16'h0100; cs_rd = 1'b1; d_addr = 16'h8003; d_we = 1'b1; blk_sel = 1'b0;
    #1;
    chk(arr_we && !arr_re && arr_addr == 15'h0001, "R11 store wins",
        {arr_we, arr_re, arr_addr}, {2'b10, 15'h0001});
    @(negedge clk); d_we = 1'b0; d_re = 1'b1; d_addr = 16'h8004; #1;
    chk(!rd_valid, "R11 code read dropped", rd_valid, 0);
    @(negedge clk); cs_rd = 1'b0; d_re = 1'b0; #1;
    chk(rd_valid && rd_src && rd_data == model(15'h0002) >> 0 & 8'hFF ? 1'b1 : rd_data == model(15'h0002)[7:0],
        "R11 load wins", {rd_valid, rd_src, rd_data}, {2'b11, model(15'h0002)[7:0]});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule